// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block sits on the receive line of a LIN slave node and handles the start of every frame: the header that the master sends. It ignores the line until it sees a dominant period long enough to be a break. It then takes the next character as the synchronisation byte and checks that its value is 0x55. From the timing of that byte it measures the master's real bit time, and it uses the measured value to receive the identifier byte that follows.

Its results appear on sticky flag outputs: break seen, identifier received, bad sync byte, identifier parity mismatch and framing error. The last identifier stays on a byte-wide output. The surrounding logic reads the flags and clears all of them with a one-cycle strobe. The nominal bit period, in clock cycles, is an input. It sets the break threshold and the sampling rate of the sync byte until a valid sync byte has been measured. From then on the measured period is used.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset all five flags are 0, the identifier output is 0x00 and the working period output equals the nominal period input.
- R2: The break flag sets once the synchronised line has been 0 for 11 × working period consecutive cycles. A dominant run one cycle shorter leaves it clear.
- R3: Until a break is detected, characters on the line change neither the identifier flag nor the identifier output.
- R4: After a break, if the next character is not 0x55 (LSB first), the sync-error flag sets and the header is abandoned. The following character then sets no identifier flag, and the identifier output and working period keep their values.
- R5: After a valid sync byte, the working period becomes the cycle count from the start-bit falling edge to the falling edge that opens data bit 7, divided by 8. Later break thresholds use this new value.
- R6: The character after a valid sync byte is sampled at mid-bit with the new period. Bit 0 is received first. If its stop bit is 1, the whole byte is latched on the identifier output and the identifier flag sets.
- R7: When the parity-check enable is 1, the parity-error flag sets if bit 6 ≠ b0^b1^b2^b4 or bit 7 ≠ ~(b1^b3^b4^b5) of the received identifier. The identifier is still latched. When the enable is 0, the flag never sets.
- R8: A stop bit sampled as 0 in the sync or identifier character sets the framing-error flag, sets no identifier flag, and returns the block to waiting for a break.
- R9: A one-cycle pulse on the clear input returns all five flags to 0 and leaves the identifier output unchanged.
- R10: The sync byte is received correctly when the master's bit time is between 0.8 and 1.25 times the working period. Sampling is realigned on each of its falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line (0 = dominant) |
| nom_period_i | input | PW | Nominal bit period in clock cycles |
| par_chk_en_i | input | 1 | Enables the identifier parity check |
| flag_clr_i | input | 1 | One-cycle strobe that clears all flags |
| brk_flag_o | output | 1 | Break detected (sticky) |
| id_flag_o | output | 1 | Identifier received (sticky) |
| sync_err_o | output | 1 | Sync byte was not 0x55 (sticky) |
| par_err_o | output | 1 | Identifier parity mismatch (sticky) |
| frame_err_o | output | 1 | Stop bit sampled as 0 (sticky) |
| id_o | output | 8 | Last received identifier byte |
| period_o | output | PW | Working bit period in clock cycles |

## Verification
The bench builds the block with an 8-bit period width and drives a nominal period of 16 cycles. With this small configuration the break threshold is only 176 cycles, so the bench can drive dominant runs one cycle either side of it, both at the nominal period and at retuned periods. A full header takes a few hundred cycles. That lets the bench sweep all 64 identifier values with correct parity, plus a set with a corrupted parity bit, while the master bit time steps through 13 to 20 cycles. This covers both ends of the sync tolerance range, and every measured period can be compared with the bit time the bench itself used.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        LHR_IDLE  = 3'd0,   // waiting for a break, line ignored
        LHR_DELIM = 3'd1,   // break seen, waiting for the line to go recessive
        LHR_SWAIT = 3'd2,   // waiting for the sync start bit
        LHR_SYNC  = 3'd3,   // receiving and timing the sync byte
        LHR_IWAIT = 3'd4,   // waiting for the identifier start bit
        LHR_ID    = 3'd5    // receiving the identifier byte
    } lhr_state_e;

    typedef struct packed {
        logic brk;
        logic idok;
        logic sync_err;
        logic par_err;
        logic frm_err;
    } lhr_flags_t;

    localparam logic [7:0] LHR_SYNC_BYTE = 8'h55;
    localparam int         LHR_BRK_BITS  = 11;
    localparam int         LHR_SYNC_FALLS = 4;   // falling edges after the start bit

    // Expected identifier protection bits {bit7, bit6} for a 6-bit identifier
    function automatic logic [1:0] lhr_id_parity(input logic [5:0] f);
        logic [1:0] p;
        p[0] = f[0] ^ f[1] ^ f[2] ^ f[4];
        p[1] = ~(f[1] ^ f[3] ^ f[4] ^ f[5]);
        return p;
    endfunction

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rxd_i,
    output logic rxd_s_o,
    output logic fall_o
);

    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [SW-1:0] pipe;
        logic          prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[SW-2:0], rxd_i};
        sync_d.prev = sync_q.pipe[SW-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;   // recessive line at reset
        else         sync_q <= sync_d;
    end

    assign rxd_s_o = sync_q.pipe[SW-1];
    assign fall_o  = sync_q.prev & ~sync_q.pipe[SW-1];

    // R10: each falling edge is reported for exactly one cycle
    assert_fall_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
    import lin_hdr_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rxd_s_i,
    input  logic [PW-1:0] per_i,
    output logic          brk_o
);

    localparam int MW = PW + 4;

    typedef struct packed {
        logic [MW-1:0] low_cnt;
    } det_t;

    det_t det_d, det_q;
    logic [MW-1:0] thr;
    logic [MW-1:0] cnt_inc;

    always_comb begin
        det_d   = det_q;
        thr     = MW'(per_i) * MW'(LHR_BRK_BITS);
        cnt_inc = det_q.low_cnt + MW'(1);
        if (rxd_s_i)
            det_d.low_cnt = '0;
        else if (det_q.low_cnt != '1)
            det_d.low_cnt = cnt_inc;
        brk_o = !rxd_s_i && (cnt_inc == thr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '0;
        else         det_q <= det_d;
    end

    // R2: one break event per dominant run
    assert_single_break_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |=> !brk_o);

endmodule

// File: rtl/lin_hdr_fsm.sv
module lin_hdr_fsm
    import lin_hdr_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rxd_s_i,
    input  logic          fall_i,
    input  logic          brk_i,
    input  logic [PW-1:0] nom_per_i,
    input  logic          par_en_i,
    input  logic          clr_i,
    output lhr_flags_t    flags_o,
    output logic [7:0]    id_o,
    output logic [PW-1:0] per_o
);

    localparam int MW = PW + 4;
    localparam logic [3:0] STOP_IDX = 4'd9;

    typedef struct packed {
        lhr_state_e    st;
        logic [PW-1:0] tmr;
        logic [3:0]    idx;     // 0 start, 1..8 data, 9 stop
        logic [7:0]    shr;
        logic [2:0]    edg;
        logic          bad;
        logic [MW-1:0] meas;
        logic [MW-1:0] cap;
        logic [PW-1:0] per;
        logic          pvld;
        logic [7:0]    id;
        lhr_flags_t    flg;
    } fsm_t;

    fsm_t r_d, r_q;

    logic [PW-1:0] eff;
    logic [PW-1:0] half_m1;
    logic [PW-1:0] full_m1;
    logic          tick;
    logic          samp;
    logic [2:0]    edg_nx;
    logic [PW:0]   quot;

    always_comb begin
        r_d     = r_q;
        eff     = r_q.pvld ? r_q.per : nom_per_i;
        half_m1 = (eff >> 1) - PW'(1);
        full_m1 = eff - PW'(1);
        tick    = (r_q.tmr == '0);
        edg_nx  = r_q.edg + 3'd1;
        quot    = r_q.cap[MW-1:3];
        samp    = 1'b0;

        if (!tick) r_d.tmr = r_q.tmr - PW'(1);
        if (clr_i) r_d.flg = '0;

        if (brk_i) begin
            r_d.flg.brk = 1'b1;
            r_d.st      = LHR_DELIM;
        end else begin
            case (r_q.st)
                LHR_IDLE: ;
                LHR_DELIM: if (rxd_s_i) r_d.st = LHR_SWAIT;
                LHR_SWAIT: if (fall_i) begin
                    r_d.st   = LHR_SYNC;
                    r_d.tmr  = half_m1;
                    r_d.idx  = '0;
                    r_d.shr  = '0;
                    r_d.edg  = '0;
                    r_d.bad  = 1'b0;
                    r_d.meas = MW'(1);
                end
                LHR_SYNC: begin
                    if (r_q.meas != '1) r_d.meas = r_q.meas + MW'(1);
                    if (fall_i) begin
                        // realign: edge k opens data bit 2k-1
                        r_d.tmr = half_m1;
                        if (r_q.edg == 3'(LHR_SYNC_FALLS)) begin
                            r_d.bad = 1'b1;
                        end else begin
                            r_d.edg = edg_nx;
                            r_d.idx = {edg_nx, 1'b0};
                            if (edg_nx == 3'(LHR_SYNC_FALLS)) r_d.cap = r_q.meas;
                        end
                    end else begin
                        samp = tick;
                    end
                end
                LHR_IWAIT: if (fall_i) begin
                    r_d.st  = LHR_ID;
                    r_d.tmr = half_m1;
                    r_d.idx = '0;
                    r_d.shr = '0;
                end
                LHR_ID: samp = tick;
                default: r_d.st = LHR_IDLE;
            endcase

            if (samp) begin
                r_d.tmr = full_m1;
                r_d.idx = r_q.idx + 4'd1;
                if (r_q.idx == 4'd0) begin
                    if (rxd_s_i) r_d.st = (r_q.st == LHR_SYNC) ? LHR_SWAIT : LHR_IWAIT;
                end else if (r_q.idx < STOP_IDX) begin
                    r_d.shr[3'(r_q.idx - 4'd1)] = rxd_s_i;
                end else if (!rxd_s_i) begin
                    r_d.flg.frm_err = 1'b1;
                    r_d.st          = LHR_IDLE;
                end else if (r_q.st == LHR_SYNC) begin
                    if (r_q.shr != LHR_SYNC_BYTE || r_q.edg != 3'(LHR_SYNC_FALLS) || r_q.bad) begin
                        r_d.flg.sync_err = 1'b1;
                        r_d.st           = LHR_IDLE;
                    end else begin
                        r_d.per  = quot[PW] ? '1 : quot[PW-1:0];
                        r_d.pvld = 1'b1;
                        r_d.st   = LHR_IWAIT;
                    end
                end else begin
                    r_d.id       = r_q.shr;
                    r_d.flg.idok = 1'b1;
                    if (par_en_i && (r_q.shr[7:6] != lhr_id_parity(r_q.shr[5:0])))
                        r_d.flg.par_err = 1'b1;
                    r_d.st = LHR_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.st  <= LHR_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags_o = r_q.flg;
    assign id_o    = r_q.id;
    assign per_o   = r_q.pvld ? r_q.per : nom_per_i;

    // R5: the stored period only changes at the end of a sync byte
    assert_per_after_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(r_q.per) |-> $past(r_q.st) == LHR_SYNC);

    // R6: the identifier flag rises only out of identifier reception
    assert_id_from_id_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.flg.idok) |-> $past(r_q.st) == LHR_ID);

    // R4: a sync error rises only out of sync reception
    assert_sync_err_from_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(r_q.flg.sync_err) |-> $past(r_q.st) == LHR_SYNC);

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int PW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rxd_i,
    input  logic [PW-1:0] nom_period_i,
    input  logic          par_chk_en_i,
    input  logic          flag_clr_i,
    output logic          brk_flag_o,
    output logic          id_flag_o,
    output logic          sync_err_o,
    output logic          par_err_o,
    output logic          frame_err_o,
    output logic [7:0]    id_o,
    output logic [PW-1:0] period_o
);

    logic       rxd_s;
    logic       fall;
    logic       brk_pulse;
    lhr_flags_t flags;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rxd_i   (rxd_i),
        .rxd_s_o (rxd_s),
        .fall_o  (fall)
    );

    lin_brk_det #(.PW(PW)) u_brk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rxd_s_i (rxd_s),
        .per_i   (period_o),
        .brk_o   (brk_pulse)
    );

    lin_hdr_fsm #(.PW(PW)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rxd_s_i   (rxd_s),
        .fall_i    (fall),
        .brk_i     (brk_pulse),
        .nom_per_i (nom_period_i),
        .par_en_i  (par_chk_en_i),
        .clr_i     (flag_clr_i),
        .flags_o   (flags),
        .id_o      (id_o),
        .per_o     (period_o)
    );

    assign brk_flag_o  = flags.brk;
    assign id_flag_o   = flags.idok;
    assign sync_err_o  = flags.sync_err;
    assign par_err_o   = flags.par_err;
    assign frame_err_o = flags.frm_err;

    // R2: a detected break always shows on the flag next cycle
    assert_break_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_pulse |=> brk_flag_o);

    // R9: clearing without a new break leaves the break flag low
    assert_clear_break_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !brk_pulse) |=> !brk_flag_o);

    // R7: a parity error needs the enable and comes with an identifier
    assert_parity_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(par_err_o) |-> ($past(par_chk_en_i) && id_flag_o));

endmodule

// File: tb/lin_hdr_rx_test.sv
`timescale 1ns/1ps
module lin_hdr_rx_test;

    localparam int PW  = 8;
    localparam int NOM = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic [PW-1:0] nom = PW'(NOM);
    logic          pen = 1'b1;
    logic          clr = 1'b0;
    logic          brk_f, id_f, sync_e, par_e, frm_e;
    logic [7:0]    id_v;
    logic [PW-1:0] per_v;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lin_hdr_rx #(.PW(PW)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rxd_i        (rxd),
        .nom_period_i (nom),
        .par_chk_en_i (pen),
        .flag_clr_i   (clr),
        .brk_flag_o   (brk_f),
        .id_flag_o    (id_f),
        .sync_err_o   (sync_e),
        .par_err_o    (par_e),
        .frame_err_o  (frm_e),
        .id_o         (id_v),
        .period_o     (per_v)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] b, input int t, input logic stop_v);
        hold(1'b0, t);
        for (int k = 0; k < 8; k++) hold(b[k], t);
        hold(stop_v, t);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic header(input int brk_len, input int t, input logic [7:0] sy,
                          input logic [7:0] idv, input logic stop_v);
        pulse_clr();
        hold(1'b0, brk_len);
        hold(1'b1, t);
        send_char(sy, t, 1'b1);
        hold(1'b1, 2 * t);
        send_char(idv, t, stop_v);
        hold(1'b1, 3 * t);
    endtask

    function automatic logic [7:0] mk_id(input logic [5:0] f);
        logic p0, p1;
        p0 = f[0] ^ f[1] ^ f[2] ^ f[4];
        p1 = ~(f[1] ^ f[3] ^ f[4] ^ f[5]);
        return {p1, p0, f};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rxd   = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] exp_id;
        int         t;
        do_reset();

        // R1: reset state
        chk("R1 brk", brk_f, 0);
        chk("R1 idflag", id_f, 0);
        chk("R1 syncerr", sync_e, 0);
        chk("R1 parerr", par_e, 0);
        chk("R1 frmerr", frm_e, 0);
        chk("R1 id", id_v, 0);
        chk("R1 period", per_v, NOM);

        // R3: characters before any break are ignored
        send_char(8'h55, NOM, 1'b1);
        hold(1'b1, 2 * NOM);
        send_char(mk_id(6'd5), NOM, 1'b1);
        hold(1'b1, 3 * NOM);
        chk("R3 idflag", id_f, 0);
        chk("R3 id", id_v, 0);
        chk("R3 brk", brk_f, 0);

        // R2: threshold at the nominal period, one cycle short
        hold(1'b0, 11 * NOM - 1);
        hold(1'b1, 40);
        chk("R2 short run", brk_f, 0);
        // R2: exactly at the threshold, full header follows
        exp_id = mk_id(6'd9);
        header(11 * NOM, NOM, 8'h55, exp_id, 1'b1);
        chk("R2 brk at threshold", brk_f, 1);
        chk("R6 idflag", id_f, 1);
        chk("R6 id", id_v, exp_id);

        // R10 / R5: master at 1.25 x working period
        do_reset();
        exp_id = mk_id(6'd42);
        header(260, 20, 8'h55, exp_id, 1'b1);
        chk("R10 slow idflag", id_f, 1);
        chk("R10 slow id", id_v, exp_id);
        chk("R5 period slow", per_v, 20);
        // R5: next break threshold follows the measured period
        pulse_clr();
        hold(1'b0, 11 * 20 - 1);
        hold(1'b1, 40);
        chk("R5 short run at 20", brk_f, 0);
        header(11 * 20, 20, 8'h55, exp_id, 1'b1);
        chk("R5 brk at 220", brk_f, 1);
        chk("R5 idflag at 220", id_f, 1);

        // R10: master at about 0.81 x working period
        do_reset();
        exp_id = mk_id(6'd17);
        header(260, 13, 8'h55, exp_id, 1'b1);
        chk("R10 fast idflag", id_f, 1);
        chk("R10 fast id", id_v, exp_id);
        chk("R5 period fast", per_v, 13);

        // R6 / R5 / R7: sweep all identifiers while the bit time drifts
        for (int i = 0; i < 64; i++) begin
            t = ((i % 16) < 8) ? 13 + (i % 8) : 20 - (i % 8);
            exp_id = mk_id(6'(i));
            header(260, t, 8'h55, exp_id, 1'b1);
            chk("R2 sweep brk", brk_f, 1);
            chk("R6 sweep idflag", id_f, 1);
            chk("R6 sweep id", id_v, exp_id);
            chk("R7 sweep parerr", par_e, 0);
            chk("R4 sweep syncerr", sync_e, 0);
            chk("R8 sweep frmerr", frm_e, 0);
            chk("R5 sweep period", per_v, t);
        end

        // R9: clear strobe
        pulse_clr();
        chk("R9 brk", brk_f, 0);
        chk("R9 idflag", id_f, 0);
        chk("R9 id kept", id_v, exp_id);

        // R7: corrupted bit 7 with check enabled
        for (int i = 0; i < 16; i++) begin
            exp_id = mk_id(6'(i * 4 + 1)) ^ 8'h80;
            header(260, 13, 8'h55, exp_id, 1'b1);
            chk("R7 parerr on", par_e, 1);
            chk("R7 idflag", id_f, 1);
            chk("R7 id latched", id_v, exp_id);
        end
        // R7: corrupted bit 6 with check disabled
        pen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            exp_id = mk_id(6'(i * 9)) ^ 8'h40;
            header(260, 13, 8'h55, exp_id, 1'b1);
            chk("R7 parerr off", par_e, 0);
            chk("R7 idflag off", id_f, 1);
            chk("R7 id off", id_v, exp_id);
        end
        pen = 1'b1;

        // R4: wrong sync bytes abandon the header
        header(260, 13, 8'h54, mk_id(6'd7), 1'b1);
        chk("R4 syncerr 54", sync_e, 1);
        chk("R4 idflag 54", id_f, 0);
        chk("R4 id kept 54", id_v, exp_id);
        chk("R4 period kept", per_v, 13);
        header(260, 13, 8'hD5, mk_id(6'd8), 1'b1);
        chk("R4 syncerr D5", sync_e, 1);
        chk("R4 idflag D5", id_f, 0);
        chk("R4 id kept D5", id_v, exp_id);
        pulse_clr();
        chk("R9 syncerr cleared", sync_e, 0);

        // R8: identifier with a dominant stop bit
        header(260, 13, 8'h55, 8'h3C, 1'b0);
        chk("R8 frmerr", frm_e, 1);
        chk("R8 idflag", id_f, 0);
        chk("R8 id kept", id_v, exp_id);
        pulse_clr();
        chk("R9 frmerr cleared", frm_e, 0);

        // R2 / R5: threshold at the measured 13-cycle period
        hold(1'b0, 11 * 13 - 1);
        hold(1'b1, 30);
        chk("R2 short run at 13", brk_f, 0);
        exp_id = mk_id(6'd33);
        header(11 * 13, 13, 8'h55, exp_id, 1'b1);
        chk("R2 brk at 143", brk_f, 1);
        chk("R6 id after 143", id_v, exp_id);

        done = 1'b1;
        finish_run();
    end

endmodule